// File: doc/BRIEF.md
# Interrupt-Controller Extension Capability and Configuration Window

This block holds the two registers that software uses to discover and turn on a virtualization extension of an interrupt controller. A read-only capability word lists what the extension offers. A writable configuration word selects which of those offerings are active. The three configuration bits that matter leave the block as plain control pins: a controller enable, an interrupt-number encoding select and a core-number encoding select.

A build-time parameter says whether the extension exists. When it does, every capability bit reads as one. Writes to the configuration word keep only the bits the capability word advertises. Once the enable bit is set, the configuration is locked: any nonzero write is refused with an error, and a write of zero releases it. When the extension is absent, the capability word reads zero and the enable is held on permanently.

Requests arrive on a 32-bit register port with valid/ready handshakes on both the request and the response side. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and is held with its data unchanged until a cycle where `rsp_ready` is high. No new request is taken while a response is waiting, so the master can apply back-pressure indefinitely without losing or reordering anything.

Top module: `cfgwin_top`

## Requirements
- R1: A read at byte offset 0x0 returns the capability word with an OK response (`rsp_err` = 0). With the extension present this word is 0xF: bit 0 means present, bit 1 means enable control, bit 2 means interrupt encoding and bit 3 means core-number encoding. With the extension absent it is 0x0.
- R2: A write to offset 0x0 gets an error response and changes neither the capability word nor the configuration word.
- R3: A write to offset 0x4 while the enable is off is accepted with an OK response and stores the written value ANDed with the capability word. Configuration bit 1 drives `cfg_enable`, bit 2 drives `cfg_int_encode` and bit 3 drives `cfg_core_encode`. The new values appear on these pins in the cycle after the request is taken.
- R4: A nonzero write to offset 0x4 while the enable is on gets an error response and leaves the configuration unchanged.
- R5: A write of zero to offset 0x4 is always accepted with an OK response, including while the enable is on.
- R6: After reset the stored configuration word is zero. With the extension present, all three control pins are low. `req_ready` is high and `rsp_valid` is low.
- R7: With the extension absent, `cfg_enable` and configuration bit 1 are always one, and `cfg_int_encode` and `cfg_core_encode` are always zero.
- R8: A read at offset 0x4 returns the current configuration word with an OK response.
- R9: A read or write at any offset other than 0x0 or 0x4 gets an error response and changes no state. Write responses and error responses carry zero data.
- R10: `req_ready` is low while a response is pending. A pending response keeps `rsp_valid`, `rsp_err` and `rsp_data` stable until it is taken with `rsp_ready`. Exactly one response follows each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (12) | Byte offset of the access |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Master takes the response |
| rsp_err | output | 1 | 1 = access refused or unknown offset |
| rsp_data | output | DATA_W (32) | Read data, zero for writes and errors |
| cfg_enable | output | 1 | Controller enable (configuration bit 1) |
| cfg_int_encode | output | 1 | Interrupt-number encoding select (configuration bit 2) |
| cfg_core_encode | output | 1 | Core-number encoding select (configuration bit 3) |

## Verification
Each of the three control pins comes straight from the stored configuration word. A wrongly stored or wrongly masked bit therefore shows on the pins one cycle after the write that caused it, and on the next read of offset 0x4. A wrong lock decision shows even sooner, as an inverted `rsp_err` on that same write's response. The bench keeps a model of the configuration word for both build variants and checks every write response, every readback and all three pins after each step of a sweep. The sweep mixes zero and nonzero values and values with high bits set.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
  localparam int unsigned CAP_OFS = 0;
  localparam int unsigned CFG_OFS = 4;

  localparam int unsigned CAP_PRESENT_BIT = 0;
  localparam int unsigned CAP_NBITS       = 4;

  localparam int unsigned CFG_EN_BIT      = 1;
  localparam int unsigned CFG_INTENC_BIT  = 2;
  localparam int unsigned CFG_COREENC_BIT = 3;

  typedef enum logic [1:0] {
    SEL_CAP  = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_NONE = 2'd2
  } win_sel_e;
endpackage

// File: rtl/cfgwin_decode.sv
module cfgwin_decode
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output win_sel_e          sel
);
  localparam logic [ADDR_W-1:0] CAP_A = ADDR_W'(CAP_OFS);
  localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_OFS);

  always_comb begin
    if (addr == CAP_A)      sel = SEL_CAP;
    else if (addr == CFG_A) sel = SEL_CFG;
    else                    sel = SEL_NONE;
  end
endmodule

// File: rtl/cfgwin_cap.sv
module cfgwin_cap
  import cfgwin_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          HAS_EXT = 1'b1
) (
  output logic [DATA_W-1:0] cap_word
);
  generate
    if (HAS_EXT) begin : g_present
      always_comb begin
        cap_word = '0;
        for (int b = 0; b < int'(CAP_NBITS); b++) cap_word[b] = 1'b1;
      end
    end else begin : g_absent
      assign cap_word = '0;
    end
  endgenerate
endmodule

// File: rtl/cfgwin_cfg_reg.sv
module cfgwin_cfg_reg
  import cfgwin_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] cap_word,
  output logic [DATA_W-1:0] cfg_word,
  output logic              wr_refused
);
  logic [DATA_W-1:0] stored_q;
  logic [DATA_W-1:0] force_mask;

  generate
    if (HAS_EXT) begin : g_free
      assign force_mask = '0;
    end else begin : g_forced
      always_comb begin
        force_mask = '0;
        force_mask[CFG_EN_BIT] = 1'b1;
      end
    end
  endgenerate

  assign cfg_word   = stored_q | force_mask;
  assign wr_refused = cfg_word[CFG_EN_BIT] && (wr_data != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stored_q <= '0;
    else if (wr_stb && !wr_refused) stored_q <= wr_data & cap_word;
  end
endmodule

// File: rtl/cfgwin_rsp.sv
module cfgwin_rsp #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              err_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  output logic              req_ready
);
  assign req_ready = !rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_err   <= err_in;
      rsp_data  <= data_in;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
  import cfgwin_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter bit          HAS_EXT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cfg_enable,
  output logic              cfg_int_encode,
  output logic              cfg_core_encode
);
  win_sel_e          sel;
  logic [DATA_W-1:0] cap_word;
  logic [DATA_W-1:0] cfg_word;
  logic              refused;
  logic              take;
  logic              err_c;
  logic [DATA_W-1:0] data_c;

  cfgwin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (req_addr),
    .sel  (sel)
  );

  cfgwin_cap #(.DATA_W(DATA_W), .HAS_EXT(HAS_EXT)) u_cap (
    .cap_word (cap_word)
  );

  assign take = req_valid && req_ready;

  cfgwin_cfg_reg #(.DATA_W(DATA_W), .HAS_EXT(HAS_EXT)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (take && req_write && (sel == SEL_CFG)),
    .wr_data    (req_wdata),
    .cap_word   (cap_word),
    .cfg_word   (cfg_word),
    .wr_refused (refused)
  );

  always_comb begin
    err_c  = 1'b0;
    data_c = '0;
    unique case (sel)
      SEL_CAP: begin
        err_c = req_write;
        if (!req_write) data_c = cap_word;
      end
      SEL_CFG: begin
        err_c = req_write && refused;
        if (!req_write) data_c = cfg_word;
      end
      default: err_c = 1'b1;
    endcase
  end

  cfgwin_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .err_in    (err_c),
    .data_in   (data_c),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .req_ready (req_ready)
  );

  assign cfg_enable      = cfg_word[CFG_EN_BIT];
  assign cfg_int_encode  = cfg_word[CFG_INTENC_BIT];
  assign cfg_core_encode = cfg_word[CFG_COREENC_BIT];
endmodule

// File: rtl/cfgwin_chk.sv
module cfgwin_chk #(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter bit          HAS_EXT = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_data,
  input logic              cfg_enable,
  input logic              cfg_int_encode,
  input logic              cfg_core_encode
);
  logic fire;
  assign fire = req_valid && req_ready;

  // R10
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) && $stable(rsp_data)));

  // R10
  rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R2
  cap_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && req_addr == ADDR_W'(0)) |=>
      (rsp_err && $stable(cfg_enable) && $stable(cfg_int_encode) && $stable(cfg_core_encode)));

  // R4
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && req_addr == ADDR_W'(4) && req_wdata != '0 && cfg_enable) |=>
      (rsp_err && $stable(cfg_enable) && $stable(cfg_int_encode) && $stable(cfg_core_encode)));

  // R5
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_write && req_addr == ADDR_W'(4) && req_wdata == '0) |=>
      (!rsp_err && !cfg_int_encode && !cfg_core_encode));

  // R9
  bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_addr != ADDR_W'(0) && req_addr != ADDR_W'(4)) |=>
      (rsp_err && rsp_data == '0 && $stable(cfg_enable) && $stable(cfg_int_encode)
       && $stable(cfg_core_encode)));

  // R7
  absent_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !HAS_EXT |-> (cfg_enable && !cfg_int_encode && !cfg_core_encode));
endmodule

bind cfgwin_top cfgwin_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_EXT(HAS_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_data(rsp_data),
  .cfg_enable(cfg_enable), .cfg_int_encode(cfg_int_encode), .cfg_core_encode(cfg_core_encode)
);

// File: tb/sim_cfgwin_top.sv
`timescale 1ns/1ps
module sim_cfgwin_top;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_valid = '0;
  logic [1:0]    rsp_ready = '0;
  logic [1:0]    req_ready, rsp_valid, rsp_err, en, ie, ce;
  logic [DW-1:0] rsp_data [2];

  cfgwin_top #(.ADDR_W(AW), .DATA_W(DW), .HAS_EXT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid[0]), .rsp_ready(rsp_ready[0]), .rsp_err(rsp_err[0]),
    .rsp_data(rsp_data[0]), .cfg_enable(en[0]), .cfg_int_encode(ie[0]),
    .cfg_core_encode(ce[0]));

  cfgwin_top #(.ADDR_W(AW), .DATA_W(DW), .HAS_EXT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid[1]), .rsp_ready(rsp_ready[1]), .rsp_err(rsp_err[1]),
    .rsp_data(rsp_data[1]), .cfg_enable(en[1]), .cfg_int_encode(ie[1]),
    .cfg_core_encode(ce[1]));

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] model [2];
  bit finished = 1'b0;

  function automatic logic [DW-1:0] cap_of(int s);
    return (s == 0) ? 32'hF : 32'h0;
  endfunction

  function automatic logic [DW-1:0] cfg_view(int s);
    return model[s] | ((s == 0) ? 32'h0 : 32'h2);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(int s, bit w, logic [AW-1:0] a, logic [DW-1:0] d, int stall,
                     output logic [DW-1:0] rd, output logic er);
    @(negedge clk);
    req_write = w; req_addr = a; req_wdata = d; req_valid[s] = 1'b1;
    @(negedge clk);
    req_valid[s] = 1'b0;
    check("R10 response after accept", {31'b0, rsp_valid[s]}, 32'd1);
    rd = rsp_data[s]; er = rsp_err[s];
    for (int k = 0; k < stall; k++) begin
      req_valid[s] = 1'b1;
      @(negedge clk);
      check("R10 held response", {rsp_valid[s], req_ready[s], rsp_err[s]}, {1'b1, 1'b0, er});
      check("R10 held data", rsp_data[s], rd);
    end
    req_valid[s] = 1'b0;
    rsp_ready[s] = 1'b1;
    @(negedge clk);
    rsp_ready[s] = 1'b0;
    check("R10 response popped", {30'b0, rsp_valid[s], req_ready[s]}, 32'd1);
  endtask

  task automatic check_pins(int s, string req);
    logic [DW-1:0] v;
    v = cfg_view(s);
    check(req, {29'b0, ce[s], ie[s], en[s]}, {29'b0, v[3], v[2], v[1]});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    logic er;
    model[0] = '0; model[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 idle", {28'b0, rsp_valid, req_ready}, {28'b0, 2'b00, 2'b11});
    check("R6 pins", {29'b0, ce[0], ie[0], en[0]}, 32'd0);
    check("R7 absent pins", {29'b0, ce[1], ie[1], en[1]}, 32'd1);

    for (int s = 0; s < 2; s++) begin
      // R1 capability
      txn(s, 1'b0, 12'h000, '0, 0, rd, er);
      check("R1 cap data", rd, cap_of(s));
      check("R1 cap ok", {31'b0, er}, 32'd0);
      // R8 config readback at reset
      txn(s, 1'b0, 12'h004, '0, 0, rd, er);
      check("R8 cfg read", rd, cfg_view(s));
      check("R8 cfg ok", {31'b0, er}, 32'd0);
    end

    // Sweep of config writes on both builds: R3 R4 R5 R7 R8
    for (int i = 0; i < 64; i++) begin
      for (int s = 0; s < 2; s++) begin
        logic [DW-1:0] wv;
        bit lock;
        wv = (i % 4 == 0) ? 32'h0 : (32'(i) * 32'h0001_0007) ^ 32'hA5A0_0000;
        lock = cfg_view(s)[1] && (wv != 0);
        txn(s, 1'b1, 12'h004, wv, (i % 8 == 3) ? 2 : 0, rd, er);
        if (!lock) model[s] = wv & cap_of(s);
        check(lock ? "R4 locked write err" : (wv == 0 ? "R5 zero write ok" : "R3 write ok"),
              {31'b0, er}, {31'b0, lock});
        check("R9 write data zero", rd, 32'h0);
        check_pins(s, (s == 0) ? "R3 pins" : "R7 forced pins");
        txn(s, 1'b0, 12'h004, '0, 0, rd, er);
        check("R8 readback", rd, cfg_view(s));
      end
    end

    // R2 capability write refused, nothing changes
    for (int s = 0; s < 2; s++) begin
      txn(s, 1'b1, 12'h004, 32'h0, 0, rd, er);
      model[s] = '0;
      txn(s, 1'b1, 12'h004, 32'h0000_000C, 0, rd, er);
      if (!cfg_view(s)[1]) model[s] = 32'hC & cap_of(s);
      txn(s, 1'b1, 12'h000, 32'hFFFF_FFFF, 1, rd, er);
      check("R2 cap write err", {31'b0, er}, 32'd1);
      txn(s, 1'b0, 12'h000, '0, 0, rd, er);
      check("R2 cap unchanged", rd, cap_of(s));
      txn(s, 1'b0, 12'h004, '0, 0, rd, er);
      check("R2 cfg unchanged", rd, cfg_view(s));
      check_pins(s, "R2 pins unchanged");
    end

    // R9 unknown offsets
    for (int s = 0; s < 2; s++) begin
      for (int a = 1; a < 16; a++) begin
        if (a == 4) continue;
        txn(s, a[0], 12'(a), 32'hFFFF_FFFF, 0, rd, er);
        check("R9 bad offset err", {31'b0, er}, 32'd1);
        check("R9 bad offset data", rd, 32'h0);
        check_pins(s, "R9 no change");
      end
      txn(s, 1'b1, 12'h800, 32'h2, 0, rd, er);
      check("R9 high offset err", {31'b0, er}, 32'd1);
      check_pins(s, "R9 no change high");
    end

    finish_run();
  end
endmodule